// File: doc/BRIEF.md
# Fair Master-Side Bus Arbiter

This block decides, on the master end of a single-wire half-duplex register bus, who talks next. One slave shares the bus. Three sources compete for it. The first is a local register access requested by the master's own logic. The second is an internal access for keep-alive polling or discovery. The third is the slave, which asks for the bus by pulling an active-low request line. When the block picks a master access, it may first emit a wake-up byte. It then starts the transaction and waits for the single reply.

A timeout guards every attempt. A failed attempt is retried until the attempt limit is reached. When the block picks the slave, it emits a one-byte grant and then keeps the bus for the slave until the slave releases its line or a longer timeout expires. Serialization and packet contents belong to neighbouring logic. This block only issues byte and start strobes, and it consumes reply strobes.

Fairness works by alternation. Once a master access has finished, a low request line wins the next decision. After a slave access, a pending master request goes first. An access already under way is never cut short, so a slave request that collides with a master access simply waits.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `slv_bus`, `byte_vld`, `acc_go` and `done` are all 0.
- R2: `rts_n` passes through a two-flop synchronizer. With the block idle and no master request, a falling `rts_n` produces the grant byte 0x00 (`byte_vld`=1) three cycles later. `slv_bus` rises in that same cycle. `slv_bus` falls three cycles after `rts_n` returns high.
- R3: After a master access completes, the block grants the slave before any further master access whenever the synchronized request line is low. When no master request is pending, the slave may be granted back to back.
- R4: After a slave access, or out of reset, a pending master request wins over a low request line. This includes a request line that falls in the same cycle as the master request. Between master sources, the internal request wins over the local one.
- R5: While an access is in progress, neither the request line nor a new master request produces a byte, a start or a grant.
- R6: If `wake_en` is high when a master access is selected, the byte 0xFF is emitted one cycle before the first `acc_go`. Retries emit no wake byte.
- R7: `acc_go` pulses one cycle after selection, or one cycle after a failed attempt ends. A reply that is sampled with `rsp_ok`=1 ends the access with `done`=1 and `result`=0 in the next cycle.
- R8: A reply with `rsp_ok`=0, or a timeout, starts a new attempt. There are at most three attempts in all. The final failure reports `result`=1 for a status error or `result`=2 for a timeout.
- R9: An attempt with no reply times out exactly `RSP_TO` cycles after its `acc_go` pulse.
- R10: If the slave does not release its line, its ownership ends `SLV_TO` cycles after the grant byte.
- R11: `rsp_vld` is ignored while the block is idle or the slave owns the bus: no `done` follows and the state is unchanged.
- R12: `acc_int` is 1 for an internal access and 0 for a local one. It is valid with `acc_go` and with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rts_n | input | 1 | Slave request line, active low, asynchronous |
| loc_req | input | 1 | Local access pending, held until `done` |
| int_req | input | 1 | Internal access pending, held until `done` |
| wake_en | input | 1 | Send the wake-up byte before the chosen master access |
| rsp_vld | input | 1 | Reply received for the current attempt |
| rsp_ok | input | 1 | Reply status was zero |
| byte_vld | output | 1 | Strobe to transmit a one-byte special packet |
| byte_val | output | 8 | Special byte value (0x00 grant, 0xFF wake) |
| acc_go | output | 1 | Start (or restart) the master transaction |
| acc_int | output | 1 | Current master access is the internal one |
| done | output | 1 | Master access finished |
| result | output | 2 | 0 ok, 1 status error, 2 timeout |
| busy | output | 1 | An access is selected or in progress |
| slv_bus | output | 1 | The slave currently owns the bus |

## Verification
Every result has a fixed due cycle. The grant byte is due three cycles after `rts_n` falls, and slave release shows three cycles after it rises. The wake byte comes one cycle after a master request is raised, and `acc_go` one cycle after that. `done` follows a sampled reply by one cycle, a timeout lands exactly `RSP_TO` cycles after `acc_go`, and a retry's `acc_go` comes one cycle after the failed attempt ends. The bench drives on the falling edge and counts falling edges from each stimulus, sampling only in the due cycle. It also checks the cycles in between for the absence of strobes. Random runs draw reply delays, statuses and silences, and a bench function derives the expected result from them.

// File: rtl/fair_bus_arbiter.sv
`timescale 1ns/1ps
module fair_bus_arbiter #(
  parameter int          RSP_TO     = 2000,
  parameter int          SLV_TO     = 50000,
  parameter int          MAX_TRIES  = 3,
  parameter logic [7:0]  GRANT_BYTE = 8'h00,
  parameter logic [7:0]  WAKE_BYTE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rts_n,
  input  logic       loc_req,
  input  logic       int_req,
  input  logic       wake_en,
  input  logic       rsp_vld,
  input  logic       rsp_ok,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic       acc_go,
  output logic       acc_int,
  output logic       done,
  output logic [1:0] result,
  output logic       busy,
  output logic       slv_bus
);
  localparam int TMAX = (RSP_TO > SLV_TO) ? RSP_TO : SLV_TO;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] RSP_LIM = TW'(RSP_TO - 1);
  localparam logic [TW-1:0] SLV_LIM = TW'(SLV_TO - 1);
  localparam logic [NW-1:0] TRY_LIM = NW'(MAX_TRIES - 1);
  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_STS = 2'd1;
  localparam logic [1:0] RES_TMO = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_GO, S_WAIT, S_SLV} st_t;
  st_t st;

  logic [1:0]    rts_q;
  logic [TW-1:0] tmr;
  logic [NW-1:0] tries;
  logic          mst_last;

  wire rts_low  = ~rts_q[1];
  wire mst_pend = loc_req | int_req;
  wire pick_slv = rts_low & (mst_last | ~mst_pend);
  wire rsp_tmo  = (tmr == RSP_LIM);
  wire slv_tmo  = (tmr == SLV_LIM);
  wire fail     = rsp_vld ? ~rsp_ok : rsp_tmo;
  wire last_try = (tries == TRY_LIM);

  assign busy    = (st != S_IDLE);
  assign slv_bus = (st == S_SLV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 2'b11;
    else        rts_q <= {rts_q[0], rts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      tries    <= '0;
      mst_last <= 1'b0;
      acc_int  <= 1'b0;
      byte_vld <= 1'b0;
      byte_val <= 8'h00;
      acc_go   <= 1'b0;
      done     <= 1'b0;
      result   <= RES_OK;
    end else begin
      byte_vld <= 1'b0;
      acc_go   <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pick_slv) begin
            byte_vld <= 1'b1;
            byte_val <= GRANT_BYTE;
            tmr      <= '0;
            st       <= S_SLV;
          end else if (mst_pend) begin
            acc_int <= int_req;
            tries   <= '0;
            st      <= S_GO;
            if (wake_en) begin
              byte_vld <= 1'b1;
              byte_val <= WAKE_BYTE;
            end
          end
        end
        S_GO: begin
          acc_go <= 1'b1;
          tmr    <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_vld || rsp_tmo) begin
            if (!fail || last_try) begin
              done     <= 1'b1;
              result   <= !fail ? RES_OK : (rsp_vld ? RES_STS : RES_TMO);
              mst_last <= 1'b1;
              st       <= S_IDLE;
            end else begin
              tries <= tries + NW'(1);
              st    <= S_GO;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_SLV: begin
          if (!rts_low || slv_tmo) begin
            mst_last <= 1'b0;
            st       <= S_IDLE;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module fair_bus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic [7:0] byte_val,
  input logic       acc_go,
  input logic       done,
  input logic       busy,
  input logic       slv_bus
);
  // R6
  wake_then_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_val == 8'hFF) |=> acc_go);
  // R2
  grant_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_val == 8'h00) |-> slv_bus);
  // R5
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_bus |-> (!acc_go && !done));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R1
  idle_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_go);
  // R8
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> !acc_go);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, acc_go, done}));
endmodule

bind fair_bus_arbiter fair_bus_arbiter_chk u_chk (.*);

// File: tb/sim_fair_bus_arbiter.sv
`timescale 1ns/1ps
module sim_fair_bus_arbiter;
  localparam int TO  = 12;
  localparam int STO = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rts_n = 1'b1, loc_req = 1'b0, int_req = 1'b0, wake_en = 1'b0;
  logic rsp_vld = 1'b0, rsp_ok = 1'b0;
  logic byte_vld, acc_go, acc_int, done, busy, slv_bus;
  logic [7:0] byte_val;
  logic [1:0] result;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fair_bus_arbiter #(.RSP_TO(TO), .SLV_TO(STO)) u0 (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .loc_req(loc_req), .int_req(int_req),
    .wake_en(wake_en), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok), .byte_vld(byte_vld),
    .byte_val(byte_val), .acc_go(acc_go), .acc_int(acc_int), .done(done),
    .result(result), .busy(busy), .slv_bus(slv_bus));

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int b0, input int b1, input int b2);
    if (b0 == 0 || b1 == 0 || b2 == 0) return 0;
    return b2;
  endfunction

  // at the acc_go cycle; runs attempts b0..b2 (0 ok, 1 bad status, 2 silent)
  task automatic mst_body(input bit intl, input int b0, input int b1, input int b2);
    int beh[3];
    bit fin = 0;
    beh[0] = b0; beh[1] = b1; beh[2] = b2;
    for (int k = 0; k < 3 && !fin; k++) begin
      if (beh[k] == 2) begin
        for (int i = 1; i < TO; i++) begin
          tick;
          chk("R9 early end", int'(done | acc_go), 0);
          chk("R5 no byte", int'(byte_vld | slv_bus), 0);
        end
        tick;
      end else begin
        int d = $urandom_range(0, TO - 2);
        for (int i = 0; i < d; i++) begin
          tick;
          chk("R5 no byte", int'(byte_vld | slv_bus), 0);
        end
        rsp_vld = 1'b1; rsp_ok = (beh[k] == 0);
        tick;
        rsp_vld = 1'b0; rsp_ok = 1'b0;
      end
      fin = (beh[k] == 0) || (k == 2);
      if (fin) begin
        chk("R7 done", int'(done), 1);
        chk("R8 result", int'(result), exp_res(b0, b1, b2));
        chk("R12 source", int'(acc_int), int'(intl));
      end else begin
        chk("R8 no done on retry", int'(done), 0);
        tick;
        chk("R8 retry go", int'(acc_go), 1);
        chk("R6 no wake on retry", int'(byte_vld), 0);
      end
    end
    if (intl) int_req = 1'b0; else loc_req = 1'b0;
  endtask

  task automatic mst_full(input bit intl, input bit wk, input int b0, input int b1, input int b2);
    if (intl) int_req = 1'b1; else loc_req = 1'b1;
    wake_en = wk;
    tick;
    chk("R6 wake byte", int'(byte_vld), int'(wk));
    if (wk) chk("R6 wake value", int'(byte_val), 8'hFF);
    wake_en = 1'b0;
    tick;
    chk("R7 go", int'(acc_go), 1);
    chk("R12 go source", int'(acc_int), int'(intl));
    mst_body(intl, b0, b1, b2);
  endtask

  task automatic run_slave(input int hold);
    rts_n = 1'b0;
    tick; chk("R2 not yet", int'(byte_vld), 0);
    tick; chk("R2 not yet", int'(byte_vld), 0);
    tick;
    chk("R2 grant", int'(byte_vld), 1);
    chk("R2 grant value", int'(byte_val), 8'h00);
    chk("R2 owner", int'(slv_bus), 1);
    repeat (hold) tick;
    rts_n = 1'b1;
    tick; tick;
    chk("R2 still owner", int'(slv_bus), 1);
    tick;
    chk("R2 released", int'(slv_bus), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    tick; tick;
    chk("R1 reset busy", int'(busy | slv_bus), 0);
    chk("R1 reset strobes", int'(byte_vld | acc_go | done), 0);
    rst_n = 1'b1;
    tick;
    chk("R1 after reset", int'(busy | byte_vld | acc_go | done), 0);

    // R11 reply while idle
    rsp_vld = 1'b1; rsp_ok = 1'b1; tick; rsp_vld = 1'b0; rsp_ok = 1'b0; tick;
    chk("R11 idle reply", int'(done | busy), 0);

    mst_full(0, 1, 0, 0, 0);
    mst_full(1, 0, 2, 2, 2);
    mst_full(0, 0, 1, 1, 1);
    mst_full(1, 1, 1, 2, 0);

    // R10 slave holds forever; R3 back-to-back grant; R11 reply while slave owns
    rts_n = 1'b0;
    tick; tick; tick;
    chk("R2 grant", int'(byte_vld), 1);
    rsp_vld = 1'b1; rsp_ok = 1'b1; tick; rsp_vld = 1'b0; rsp_ok = 1'b0;
    chk("R11 slave reply", int'(done), 0);
    chk("R11 slave owner kept", int'(slv_bus), 1);
    for (int i = 2; i < STO; i++) tick;
    chk("R10 before timeout", int'(slv_bus), 1);
    tick;
    chk("R10 slave timeout", int'(slv_bus), 0);
    tick;
    chk("R3 slave again", int'(byte_vld & slv_bus), 1);
    rts_n = 1'b1;
    tick; tick; tick;
    chk("R2 released", int'(slv_bus), 0);

    // R4 collision: line falls with master request, master wins; R5 wait; R3 alternation
    rts_n = 1'b0; loc_req = 1'b1;
    tick; chk("R4 master wins", int'(byte_vld), 0);
    tick; chk("R4 master go", int'(acc_go), 1);
    mst_body(0, 1, 0, 0);
    loc_req = 1'b1;
    tick;
    chk("R3 grant after master", int'(byte_vld & slv_bus), 1);
    chk("R3 grant value", int'(byte_val), 0);
    repeat (4) tick;
    rts_n = 1'b1; tick; rts_n = 1'b0; tick; tick;
    chk("R2 released", int'(slv_bus), 0);
    tick;
    chk("R4 master after slave", int'(byte_vld | slv_bus), 0);
    chk("R4 master selected", int'(busy), 1);
    tick;
    chk("R4 master go", int'(acc_go), 1);
    mst_body(0, 0, 0, 0);
    tick;
    chk("R3 grant after master", int'(byte_vld & slv_bus), 1);
    rts_n = 1'b1;
    tick; tick; tick;
    chk("R2 released", int'(slv_bus), 0);

    // R4 internal over local
    loc_req = 1'b1; int_req = 1'b1;
    tick; tick;
    chk("R4 internal first", int'(acc_go & acc_int), 1);
    mst_body(1, 0, 0, 0);
    tick; tick;
    chk("R12 local next", int'(acc_go), 1);
    chk("R12 local source", int'(acc_int), 0);
    mst_body(0, 2, 0, 0);

    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 3) == 0) run_slave($urandom_range(0, 15));
      else mst_full(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2));
      repeat ($urandom_range(0, 2)) tick;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule